// File: doc/BRIEF.md
# Pause-Width Frame Transmitter

This block sends a frame of up to 32 bits from a reader to a card on one modulation line. Each bit is coded by how long it lasts. A bit opens with a short carrier-off pause, during which `mod_out` is high. The carrier then comes back on, with `mod_out` low, until the bit period ends. A transmitted 1 lasts longer than a transmitted 0. Each data bit is XORed with a keystream bit from an external generator before it is coded. The block sends one `ks_adv` pulse to that generator for every bit it takes. One extra pause after the last bit marks the end of the frame.

All timing counts a free-running 1.5 MHz tick enable (`tick`), so one tick is 2/3 µs. The block keeps a timestamp of the planned end of the last frame. The gap before the next frame is measured from that timestamp, which lets a caller issue frames back to back with an exact spacing. The timestamp is updated by adding planned durations, never by sampling the time a segment actually finishes, so the schedule does not drift. The tick count and the timestamp both start at 0 after reset.

The sequencer has five states:
- ST_IDLE: waiting for a start strobe.
- ST_GAP: holding off until the frame gap has elapsed.
- ST_PAUSE: carrier-off pause of a data bit.
- ST_MARK: carrier-on remainder of a data bit.
- ST_TRAIL: closing pause.

The transitions are:
- ST_IDLE to ST_GAP (start, gap still running).
- ST_IDLE to ST_PAUSE (start, gap already over, length above 0).
- ST_IDLE to ST_TRAIL (start, gap already over, length 0).
- ST_GAP to ST_PAUSE or ST_TRAIL (gap deadline reached).
- ST_PAUSE to ST_MARK (pause over).
- ST_MARK to ST_PAUSE (next bit).
- ST_MARK to ST_TRAIL (last bit over).
- ST_TRAIL to ST_IDLE (frame over; done pulse).

Top module: `pause_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `mod_out`, `busy` and `done` are 0. The tick count and the last-frame-end timestamp start at 0.
- R2: Every bit begins with `mod_out` = 1 for exactly PAUSE_TICKS (30) ticks, after which `mod_out` returns to 0.
- R3: A transmitted 1 lasts ONE_TICKS (150) ticks and a transmitted 0 lasts ZERO_TICKS (90) ticks, each counted from its own pause start and including the pause.
- R4: The first pause of a frame (or its closing pause when the length is 0) begins when the tick count equals the last-frame-end timestamp plus GAP_TICKS (330).
- R5: If that point is not later than T when the start strobe is accepted, the first pause begins at once. Here T is the tick count at the start-cycle edge, which is the current count plus 1 when `tick` is high in that cycle. `mod_out` rises as the count reaches T, and the rest of the schedule follows from T.
- R6: Bits are sent least significant first. Transmitted bit k is `frame[k]` XOR the `ks_bit` value present in the cycle that bit is taken. `ks_adv` is high for exactly one cycle per bit, in that same cycle, so a frame of length n gives exactly n pulses.
- R7: After the last bit, one more pause of PAUSE_TICKS ticks is sent, and then `mod_out` returns to 0. `done` is high for exactly one cycle, starting with the edge at which that closing pause ends. The timestamp becomes the planned tick count at that edge.
- R8: A start strobe while `busy` is 1 is ignored. The frame in progress keeps its timing, bits and keystream pulse count.
- R9: A length of 0 gives only the frame gap and the closing pause, with no `ks_adv` pulse.
- R10: A length above MAX_BITS (32) is treated as MAX_BITS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 1.5 MHz timing enable, one cycle wide |
| start | input | 1 | Request to send the frame presented on `frame` and `len` |
| frame | input | 32 | Frame word, bit 0 sent first |
| len | input | 6 | Number of bits to send |
| ks_bit | input | 1 | Current keystream bit from the external generator |
| ks_adv | output | 1 | Advance request to the keystream generator, one per bit |
| mod_out | output | 1 | Modulation: 1 = carrier off (pause), 0 = carrier on |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame ends |

## Verification
The timestamp is kept in the same register that holds the running deadline. A wrong deadline therefore shows up on the first edge of `mod_out` of the affected frame, as a pause that rises or falls early or late by a whole number of ticks. If the error is carried in the timestamp instead, it shows up as a wrong gap at the start of the next frame. A wrong bit index or a wrong keystream sample changes that bit's period from 150 to 90 ticks or the reverse, so the very next rising edge moves and every later edge moves with it. A dropped or doubled advance request shows at once as a wrong count of `ks_adv` pulses for the frame.

// File: rtl/pft_pkg.sv
package pft_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_PAUSE,
        ST_MARK,
        ST_TRAIL
    } pft_state_e;
endpackage

// File: rtl/pft_timebase.sv
module pft_timebase #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [TS_W-1:0] now_next
);
    logic [TS_W-1:0] now_q;

    // tick count as it stands after the current edge
    assign now_next = now_q + (tick ? TS_W'(1) : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_next;
    end
endmodule

// File: rtl/pft_bitsel.sv
module pft_bitsel #(
    parameter int MAX_BITS = 32,
    parameter int IDX_W    = 5
) (
    input  logic [MAX_BITS-1:0] word,
    input  logic [IDX_W-1:0]    idx,
    input  logic                ks_bit,
    output logic                tx_bit
);
    // data bit scrambled with the keystream
    assign tx_bit = word[idx] ^ ks_bit;
endmodule

// File: rtl/pft_sequencer.sv
module pft_sequencer
    import pft_pkg::*;
#(
    parameter int MAX_BITS    = 32,
    parameter int TS_W        = 32,
    parameter int PAUSE_TICKS = 30,
    parameter int ONE_TICKS   = 150,
    parameter int ZERO_TICKS  = 90,
    parameter int GAP_TICKS   = 330,
    parameter int LEN_W       = 6,
    parameter int IDX_W       = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                start,
    input  logic [MAX_BITS-1:0] frame,
    input  logic [LEN_W-1:0]    len,
    input  logic [TS_W-1:0]     now_next,
    input  logic                tx_bit,
    output logic [MAX_BITS-1:0] sel_word,
    output logic [IDX_W-1:0]    sel_idx,
    output logic                ks_adv,
    output logic                mod_out,
    output logic                busy,
    output logic                done,
    output pft_state_e          state_o
);
    localparam logic [TS_W-1:0]  PAUSE_T   = TS_W'(PAUSE_TICKS);
    localparam logic [TS_W-1:0]  ONE_REST  = TS_W'(ONE_TICKS - PAUSE_TICKS);
    localparam logic [TS_W-1:0]  ZERO_REST = TS_W'(ZERO_TICKS - PAUSE_TICKS);
    localparam logic [TS_W-1:0]  GAP_T     = TS_W'(GAP_TICKS);
    localparam logic [LEN_W-1:0] MAX_LEN   = LEN_W'(MAX_BITS);

    pft_state_e          state, nstate;
    logic [TS_W-1:0]     mark, nmark;      // running deadline, and last frame end while idle
    logic [IDX_W-1:0]    idx, nidx;
    logic [LEN_W-1:0]    len_q, len_eff;
    logic [MAX_BITS-1:0] frame_q;
    logic                cur_bit;
    logic                done_q;
    logic                load;

    logic                seg_end;
    logic [TS_W-1:0]     launch_at;
    logic [TS_W-1:0]     lead;
    logic                must_wait;
    logic                last_bit;

    assign seg_end   = tick && (now_next == mark);
    assign launch_at = mark + GAP_T;
    assign lead      = launch_at - now_next;
    assign must_wait = !lead[TS_W-1] && (lead != '0);
    assign len_eff   = (len > MAX_LEN) ? MAX_LEN : len;
    assign last_bit  = ((LEN_W'(idx) + LEN_W'(1)) == len_q);

    // next-state and deadline planning
    always_comb begin
        nstate   = state;
        nmark    = mark;
        nidx     = idx;
        load     = 1'b0;
        sel_word = frame_q;
        sel_idx  = '0;
        unique case (state)
            ST_IDLE: begin
                sel_word = frame;
                if (start) begin
                    if (must_wait) begin
                        nstate = ST_GAP;
                        nmark  = launch_at;
                    end else if (len_eff == '0) begin
                        nstate = ST_TRAIL;
                        nmark  = now_next + PAUSE_T;
                    end else begin
                        nstate = ST_PAUSE;
                        nmark  = now_next + PAUSE_T;
                        nidx   = '0;
                        load   = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (seg_end) begin
                    nmark = mark + PAUSE_T;
                    nidx  = '0;
                    if (len_q == '0) begin
                        nstate = ST_TRAIL;
                    end else begin
                        nstate = ST_PAUSE;
                        load   = 1'b1;
                    end
                end
            end
            ST_PAUSE: begin
                if (seg_end) begin
                    nstate = ST_MARK;
                    nmark  = mark + (cur_bit ? ONE_REST : ZERO_REST);
                end
            end
            ST_MARK: begin
                sel_idx = idx + IDX_W'(1);
                if (seg_end) begin
                    nmark = mark + PAUSE_T;
                    if (last_bit) begin
                        nstate = ST_TRAIL;
                    end else begin
                        nstate = ST_PAUSE;
                        nidx   = idx + IDX_W'(1);
                        load   = 1'b1;
                    end
                end
            end
            ST_TRAIL: begin
                if (seg_end) nstate = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mark    <= '0;
            idx     <= '0;
            len_q   <= '0;
            frame_q <= '0;
            cur_bit <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state  <= nstate;
            mark   <= nmark;
            idx    <= nidx;
            done_q <= (state == ST_TRAIL) && seg_end;
            if (load) cur_bit <= tx_bit;
            if (state == ST_IDLE && start) begin
                frame_q <= frame;
                len_q   <= len_eff;
            end
        end
    end

    // outputs
    always_comb begin
        mod_out = (state == ST_PAUSE) || (state == ST_TRAIL);
        busy    = (state != ST_IDLE);
        ks_adv  = load;
        done    = done_q;
        state_o = state;
    end
endmodule

// File: rtl/pause_frame_tx.sv
module pause_frame_tx
    import pft_pkg::*;
#(
    parameter int MAX_BITS    = 32,
    parameter int TS_W        = 32,
    parameter int PAUSE_TICKS = 30,
    parameter int ONE_TICKS   = 150,
    parameter int ZERO_TICKS  = 90,
    parameter int GAP_TICKS   = 330,
    localparam int LEN_W      = $clog2(MAX_BITS + 1),
    localparam int IDX_W      = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                start,
    input  logic [MAX_BITS-1:0] frame,
    input  logic [LEN_W-1:0]    len,
    input  logic                ks_bit,
    output logic                ks_adv,
    output logic                mod_out,
    output logic                busy,
    output logic                done
);
    logic [TS_W-1:0]     now_next;
    logic [MAX_BITS-1:0] sel_word;
    logic [IDX_W-1:0]    sel_idx;
    logic                tx_bit;
    pft_state_e          fsm_state;

    pft_timebase #(.TS_W(TS_W)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .now_next (now_next)
    );

    pft_bitsel #(.MAX_BITS(MAX_BITS), .IDX_W(IDX_W)) u_sel (
        .word   (sel_word),
        .idx    (sel_idx),
        .ks_bit (ks_bit),
        .tx_bit (tx_bit)
    );

    pft_sequencer #(
        .MAX_BITS    (MAX_BITS),
        .TS_W        (TS_W),
        .PAUSE_TICKS (PAUSE_TICKS),
        .ONE_TICKS   (ONE_TICKS),
        .ZERO_TICKS  (ZERO_TICKS),
        .GAP_TICKS   (GAP_TICKS),
        .LEN_W       (LEN_W),
        .IDX_W       (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (start),
        .frame    (frame),
        .len      (len),
        .now_next (now_next),
        .tx_bit   (tx_bit),
        .sel_word (sel_word),
        .sel_idx  (sel_idx),
        .ks_adv   (ks_adv),
        .mod_out  (mod_out),
        .busy     (busy),
        .done     (done),
        .state_o  (fsm_state)
    );
endmodule

// File: rtl/pft_checks.sv
module pft_checks
    import pft_pkg::*;
#(
    parameter int PAUSE_TICKS = 30,
    parameter int ONE_TICKS   = 150,
    parameter int ZERO_TICKS  = 90
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       mod_out,
    input logic       busy,
    input logic       done,
    input logic       ks_adv,
    input pft_state_e state
);
    logic [15:0] hi_cnt;
    logic [15:0] lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            if (!mod_out)  hi_cnt <= '0;
            else if (tick) hi_cnt <= hi_cnt + 16'd1;
            if (state != ST_MARK) lo_cnt <= '0;
            else if (tick)        lo_cnt <= lo_cnt + 16'd1;
        end
    end

    // R1: line quiet while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mod_out);

    // R2: every pause spans exactly the pause width
    a_r2_pause_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_out) |-> (hi_cnt == 16'(PAUSE_TICKS)));

    // R3: carrier-on part of a bit matches one of the two coded periods
    a_r3_bit_period: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_MARK && $past(state) == ST_MARK) |->
        (lo_cnt == 16'(ONE_TICKS - PAUSE_TICKS) || lo_cnt == 16'(ZERO_TICKS - PAUSE_TICKS)));

    // R6: each keystream advance starts a data pause
    a_r6_adv_starts_pause: assert property (@(posedge clk) disable iff (!rst_n)
        ks_adv |=> (state == ST_PAUSE && mod_out));

    // R7: closing pause ends with a done pulse
    a_r7_done_after_trail: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_TRAIL && state == ST_IDLE) |-> done);

    // R7: done only while the line is quiet and idle
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mod_out));
endmodule

bind pause_frame_tx pft_checks #(
    .PAUSE_TICKS (PAUSE_TICKS),
    .ONE_TICKS   (ONE_TICKS),
    .ZERO_TICKS  (ZERO_TICKS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .mod_out (mod_out),
    .busy    (busy),
    .done    (done),
    .ks_adv  (ks_adv),
    .state   (fsm_state)
);

// File: tb/pause_frame_tx_test.sv
module pause_frame_tx_test;
    localparam int LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] frame = '0;
    logic [5:0]  len = '0;
    logic        ks_bit;
    logic        ks_adv, mod_out, busy, done;
    logic        tick;
    logic [31:0] cyc = '0;
    logic [31:0] tb_now;
    int          adv_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit timeout = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;
    assign tick = ~cyc[0];

    always @(posedge clk or negedge rst_n)
        if (!rst_n)    tb_now <= '0;
        else if (tick) tb_now <= tb_now + 1;

    always @(posedge clk or negedge rst_n)
        if (!rst_n)      adv_cnt <= 0;
        else if (ks_adv) adv_cnt <= adv_cnt + 1;

    function automatic logic ks_fn(input int k);
        logic [31:0] v;
        v = k;
        return v[0] ^ v[2] ^ v[3];
    endfunction

    assign ks_bit = ks_fn(adv_cnt);

    pause_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .frame(frame), .len(len), .ks_bit(ks_bit),
        .ks_adv(ks_adv), .mod_out(mod_out), .busy(busy), .done(done)
    );

    // port monitor, sampled away from the active edge
    longint rise_t [0:39];
    longint fall_t [0:39];
    int     n_rise, n_fall, n_done;
    longint done_t;
    logic   prev_mod = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mod_out && !prev_mod && n_rise < 40) begin
                rise_t[n_rise] = tb_now;
                n_rise = n_rise + 1;
            end
            if (!mod_out && prev_mod && n_fall < 40) begin
                fall_t[n_fall] = tb_now;
                n_fall = n_fall + 1;
            end
            if (done) begin
                done_t = tb_now;
                n_done = n_done + 1;
            end
        end
        prev_mod = mod_out;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    longint exp_last = 0;

    task automatic send(input logic [31:0] f, input int l, input bit retrig);
        longint st, t0, sched, t;
        int     base, eff;
        logic   b;
        while (busy && cyc < LIMIT) @(negedge clk);
        n_rise = 0; n_fall = 0; n_done = 0;
        base  = adv_cnt;
        st    = tb_now + tick;
        t0    = exp_last + 330;
        sched = (t0 > st) ? t0 : st;
        frame = f; len = 6'(l); start = 1'b1;
        @(negedge clk);
        start = 1'b0; frame = ~f; len = 6'd3;
        if (retrig) begin
            repeat (50) @(negedge clk);
            frame = 32'h0; len = 6'd3; start = 1'b1;   // R8: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (n_done == 0 && cyc < LIMIT) @(negedge clk);
        if (cyc >= LIMIT) timeout = 1;
        repeat (3) @(negedge clk);
        eff = (l > 32) ? 32 : l;
        t = sched;
        for (int k = 0; k < eff; k++) begin
            b = f[k] ^ ks_fn(base + k);
            chk(rise_t[k] == t, (k == 0) ? ((t0 > st) ? "R4" : "R5") : "R3,R6",
                $sformatf("pause %0d start len=%0d", k, l), rise_t[k], t);
            chk(fall_t[k] == t + 30, "R2", $sformatf("pause %0d end", k), fall_t[k], t + 30);
            t = t + (b ? 150 : 90);
        end
        if (eff == 0)
            chk(rise_t[0] == t, (t0 > st) ? "R4,R9" : "R5,R9", "closing pause start", rise_t[0], t);
        else
            chk(rise_t[eff] == t, "R7", "closing pause start", rise_t[eff], t);
        chk(fall_t[eff] == t + 30, "R7", "closing pause end", fall_t[eff], t + 30);
        chk(done_t == t + 30, "R7", "done time", done_t, t + 30);
        chk(n_done == 1, "R7", "done pulse count", n_done, 1);
        chk(n_rise == eff + 1, (l > 32) ? "R10" : "R8", "pause count", n_rise, eff + 1);
        chk(adv_cnt - base == eff, (eff == 0) ? "R9" : "R6", "keystream advances",
            adv_cnt - base, eff);
        chk(!mod_out && !busy, "R1", "idle after frame", mod_out, 0);
        exp_last = t + 30;
    endtask

    initial begin
        n_rise = 0; n_fall = 0; n_done = 0; done_t = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!mod_out, "R1", "mod_out after reset", mod_out, 0);
        chk(!busy,    "R1", "busy after reset", busy, 0);
        chk(!done,    "R1", "done after reset", done, 0);
        chk(!ks_adv,  "R1", "ks_adv after reset", ks_adv, 0);

        // R4: first frame measured from the reset timestamp
        send(32'h0000_00A5, 8, 0);
        // back-to-back sweep over short lengths and two patterns
        for (int l = 0; l <= 12; l++) send(32'hB6D3_5A9C, l, 0);
        for (int l = 1; l <= 6; l++)  send(32'h0000_0000, l, 0);
        // R5: gap already elapsed before start
        repeat (900) @(negedge clk);
        send(32'h1234_5678, 10, 0);
        repeat (777) @(negedge clk);
        send(32'h0000_0000, 0, 0);
        // R8: full-width frame with a start during transmission
        send(32'hFFFF_FFFF, 32, 1);
        // R10: over-long length clamps to the word width
        send(32'h0F0F_3C3C, 40, 0);

        if (timeout || cyc >= LIMIT) chk(0, "R1", "watchdog expired", cyc, LIMIT);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // watchdog for a hang outside the guarded loops
    initial begin
        #(LIMIT * 5 + 5000);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, LIMIT);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule